// File: doc/BRIEF.md
# Packed signed compare mask unit

This block compares two 64-bit packed operands lane by lane and returns a 64-bit mask. The operands are named destination and source. A 2-bit size code splits both operands into eight byte lanes, four 16-bit lanes or two 32-bit lanes. Each lane holds a signed two's-complement value. A result lane is all ones when the destination lane is strictly greater than the source lane, and all zeros otherwise. The mask is meant for later select, blend or count logic in a packed-integer datapath.

One set of per-byte comparators serves every lane size. Each byte reports three flags: equality, unsigned greater-than and signed greater-than. A merge stage chains these flags from the top byte of a lane down to its bottom byte. Only the top byte of each lane uses the signed rule, and the chains break at lane edges. The result is registered. A valid flag follows the input strobe by one clock. The block updates no status or condition flags.

Top module: `sgc_mask_unit`

## Requirements
- R1: A synchronous, active-high `rst` forces `out_valid` to 0 and `mask_o` to all zeros on the next clock edge.
- R2: `out_valid` equals `in_valid` delayed by exactly one clock. The mask for an accepted operand pair appears in the cycle where `out_valid` is 1.
- R3: With `size_i` = 2'b00 there are eight 8-bit lanes; lane k occupies bits 8k+7:8k. Result lane k is 8'hFF when the signed destination byte is greater than the signed source byte, else 8'h00.
- R4: With `size_i` = 2'b01 there are four 16-bit lanes; lane k occupies bits 16k+15:16k. Each lane is 16'hFFFF on signed greater-than, else 16'h0000.
- R5: With `size_i` = 2'b10 there are two 32-bit lanes, at bits 31:0 and 63:32. Each lane is 32'hFFFFFFFF on signed greater-than, else zero.
- R6: The test is strict. Lanes whose destination and source values are equal produce zero in every lane size.
- R7: Every result lane is uniform: all ones or all zeros across the full lane width, never a mixture.
- R8: Size code 2'b11 is reserved and produces an all-zero mask. `out_valid` still follows `in_valid` as in R2.
- R9: Each lane result depends only on that lane's bits in the two operands. No carry, borrow or sign information passes across a lane boundary.
- R10: While `in_valid` is 0, the block ignores `dst_i`, `src_i` and `size_i`, and `mask_o` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair and size code are valid this cycle |
| dst_i | input | 64 | Destination operand, packed signed lanes |
| src_i | input | 64 | Source operand, packed signed lanes |
| size_i | input | 2 | Lane size: 00 byte, 01 16-bit, 10 32-bit, 11 reserved |
| out_valid | output | 1 | Mask register holds a new result |
| mask_o | output | 64 | Registered lane mask |

## Verification
The assertions assume that `in_valid`, `size_i` and both operands are stable at the sampling edge and never unknown once reset is released. The lane checks use `$past` of those inputs, and they only make sense if each input word was a real request. Reset is assumed to be held from time zero until after the first edge, so that the hold and valid properties start from a known register state. The bench keeps to these assumptions. It changes every input only on the falling clock edge and drives defined values from the first cycle. When it wants to test R10, it places random data on idle cycles with the strobe low.

// File: rtl/sgc_pkg.sv
package sgc_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_WORD  = 2'b01,
    SZ_DWORD = 2'b10,
    SZ_RSVD  = 2'b11
  } lane_size_e;

  typedef struct packed {
    logic eq;
    logic ugt;
    logic sgt;
  } byte_flags_t;

  // One subtractor per byte: borrow gives unsigned order, sign bits fix signed order.
  function automatic byte_flags_t compare_byte(input logic [BYTE_W-1:0] a,
                                               input logic [BYTE_W-1:0] b);
    logic [BYTE_W:0] diff;
    byte_flags_t     f;
    diff  = {1'b0, a} - {1'b0, b};
    f.eq  = (diff[BYTE_W-1:0] == '0);
    f.ugt = !diff[BYTE_W] && !f.eq;
    f.sgt = (a[BYTE_W-1] ^ b[BYTE_W-1]) ? b[BYTE_W-1] : f.ugt;
    return f;
  endfunction

endpackage

// File: rtl/sgc_byte_cmp.sv
module sgc_byte_cmp
  import sgc_pkg::*;
#(
  parameter int unsigned NB = 8
) (
  input  logic [NB*BYTE_W-1:0] dst_i,
  input  logic [NB*BYTE_W-1:0] src_i,
  output logic [NB-1:0]        eq_o,
  output logic [NB-1:0]        ugt_o,
  output logic [NB-1:0]        sgt_o
);

  for (genvar i = 0; i < NB; i++) begin : g_byte
    byte_flags_t flags;
    assign flags    = compare_byte(dst_i[i*BYTE_W +: BYTE_W], src_i[i*BYTE_W +: BYTE_W]);
    assign eq_o[i]  = flags.eq;
    assign ugt_o[i] = flags.ugt;
    assign sgt_o[i] = flags.sgt;
  end

endmodule

// File: rtl/sgc_lane_merge.sv
module sgc_lane_merge #(
  parameter int unsigned NB         = 8,
  parameter int unsigned LANE_BYTES = 1,
  localparam int unsigned LN        = NB / LANE_BYTES
) (
  input  logic [NB-1:0] eq_i,
  input  logic [NB-1:0] ugt_i,
  input  logic [NB-1:0] sgt_i,
  output logic [LN-1:0] lane_gt_o
);

  // Not every flag feeds every lane size.
  logic unused_flags;
  assign unused_flags = ^{eq_i, ugt_i, sgt_i};

  for (genvar l = 0; l < LN; l++) begin : g_lane
    localparam int unsigned TOP = l * LANE_BYTES + LANE_BYTES - 1;
    always_comb begin
      logic hit;
      logic tie;
      hit = sgt_i[TOP];
      tie = eq_i[TOP];
      for (int k = int'(LANE_BYTES) - 2; k >= 0; k--) begin
        hit = hit | (tie & ugt_i[l * LANE_BYTES + k]);
        tie = tie & eq_i[l * LANE_BYTES + k];
      end
      lane_gt_o[l] = hit;
    end
  end

endmodule

// File: rtl/sgc_mask_expand.sv
module sgc_mask_expand
  import sgc_pkg::*;
#(
  parameter int unsigned NB = 8
) (
  input  logic [1:0]           size_i,
  input  logic [NB-1:0]        gt_b_i,
  input  logic [NB/2-1:0]      gt_w_i,
  input  logic [NB/4-1:0]      gt_d_i,
  output logic [NB-1:0]        byte_sel_o,
  output logic [NB*BYTE_W-1:0] mask_o
);

  lane_size_e size_q;
  assign size_q = lane_size_e'(size_i);

  for (genvar i = 0; i < NB; i++) begin : g_byte
    always_comb begin
      case (size_q)
        SZ_BYTE:  byte_sel_o[i] = gt_b_i[i];
        SZ_WORD:  byte_sel_o[i] = gt_w_i[i/2];
        SZ_DWORD: byte_sel_o[i] = gt_d_i[i/4];
        default:  byte_sel_o[i] = 1'b0;
      endcase
    end
    assign mask_o[i*BYTE_W +: BYTE_W] = {BYTE_W{byte_sel_o[i]}};
  end

endmodule

// File: rtl/sgc_mask_unit.sv
module sgc_mask_unit
  import sgc_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  localparam int unsigned NB    = DATA_W / BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [1:0]        size_i,
  output logic              out_valid,
  output logic [DATA_W-1:0] mask_o
);

  // Named internal events
  logic [NB-1:0]     byte_eq;
  logic [NB-1:0]     byte_ugt;
  logic [NB-1:0]     byte_sgt;
  logic [NB-1:0]     lane_gt_b;
  logic [NB/2-1:0]   lane_gt_w;
  logic [NB/4-1:0]   lane_gt_d;
  logic [NB-1:0]     byte_sel;
  logic [DATA_W-1:0] mask_next;
  logic              capture;

  sgc_byte_cmp #(.NB(NB)) u_cmp (
    .dst_i (dst_i),
    .src_i (src_i),
    .eq_o  (byte_eq),
    .ugt_o (byte_ugt),
    .sgt_o (byte_sgt)
  );

  sgc_lane_merge #(.NB(NB), .LANE_BYTES(1)) u_merge_b (
    .eq_i (byte_eq), .ugt_i (byte_ugt), .sgt_i (byte_sgt), .lane_gt_o (lane_gt_b)
  );

  sgc_lane_merge #(.NB(NB), .LANE_BYTES(2)) u_merge_w (
    .eq_i (byte_eq), .ugt_i (byte_ugt), .sgt_i (byte_sgt), .lane_gt_o (lane_gt_w)
  );

  sgc_lane_merge #(.NB(NB), .LANE_BYTES(4)) u_merge_d (
    .eq_i (byte_eq), .ugt_i (byte_ugt), .sgt_i (byte_sgt), .lane_gt_o (lane_gt_d)
  );

  sgc_mask_expand #(.NB(NB)) u_expand (
    .size_i     (size_i),
    .gt_b_i     (lane_gt_b),
    .gt_w_i     (lane_gt_w),
    .gt_d_i     (lane_gt_d),
    .byte_sel_o (byte_sel),
    .mask_o     (mask_next)
  );

  assign capture = in_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      mask_o    <= '0;
    end else begin
      out_valid <= capture;
      if (capture) mask_o <= mask_next;
    end
  end

endmodule

// File: rtl/sgc_mask_unit_chk.sv
module sgc_mask_unit_chk #(
  parameter int unsigned DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [DATA_W-1:0] dst_i,
  input logic [DATA_W-1:0] src_i,
  input logic [1:0]        size_i,
  input logic              out_valid,
  input logic [DATA_W-1:0] mask_o
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && mask_o == '0));

  assert_valid_rise_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_valid_drop_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_byte_top_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && size_i == 2'b00) |=>
      mask_o[DATA_W-1 -: 8] == (($signed($past(dst_i[DATA_W-1 -: 8])) >
                                 $signed($past(src_i[DATA_W-1 -: 8]))) ? 8'hFF : 8'h00));

  assert_word_low_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && size_i == 2'b01) |=>
      mask_o[15:0] == (($signed($past(dst_i[15:0])) >
                        $signed($past(src_i[15:0]))) ? 16'hFFFF : 16'h0000));

  assert_dword_low_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && size_i == 2'b10) |=>
      mask_o[31:0] == (($signed($past(dst_i[31:0])) >
                        $signed($past(src_i[31:0]))) ? 32'hFFFF_FFFF : 32'h0));

  assert_equal_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dst_i == src_i) |=> mask_o == '0);

  assert_word_uniform_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && size_i == 2'b01) |=>
      (mask_o[15:8] == mask_o[7:0] && (mask_o[7:0] == 8'h00 || mask_o[7:0] == 8'hFF)));

  assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && size_i == 2'b11) |=> mask_o == '0);

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(mask_o));

endmodule

bind sgc_mask_unit sgc_mask_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .dst_i     (dst_i),
  .src_i     (src_i),
  .size_i    (size_i),
  .out_valid (out_valid),
  .mask_o    (mask_o)
);

// File: tb/sgc_mask_unit_test.sv
`timescale 1ns/1ps
module sgc_mask_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] dst_i = '0;
  logic [63:0] src_i = '0;
  logic [1:0]  size_i = 2'b00;
  logic        out_valid;
  logic [63:0] mask_o;

  int compared = 0;
  int mismatched = 0;

  logic [63:0] q_mask[$];
  string       q_tag[$];
  logic        exp_v = 1'b0;
  logic        exp_rst = 1'b1;
  logic [63:0] last_mask = '0;

  always #5 clk = ~clk;

  sgc_mask_unit uut (
    .clk (clk), .rst (rst), .in_valid (in_valid), .dst_i (dst_i),
    .src_i (src_i), .size_i (size_i), .out_valid (out_valid), .mask_o (mask_o)
  );

  // Bias each lane by its sign bit and compare unsigned.
  function automatic logic [63:0] model(input logic [63:0] d, input logic [63:0] s,
                                        input logic [1:0] sz);
    int unsigned w;
    logic [63:0] lm, bias, a, b, r;
    r = '0;
    case (sz)
      2'b00: w = 8;
      2'b01: w = 16;
      2'b10: w = 32;
      default: w = 0;
    endcase
    if (w == 0) return '0;
    lm   = (64'h1 << w) - 64'h1;
    bias = 64'h1 << (w - 1);
    for (int l = 0; l < 64 / int'(w); l++) begin
      a = (d >> (l * w)) & lm;
      b = (s >> (l * w)) & lm;
      if ((a ^ bias) > (b ^ bias)) r = r | (lm << (l * w));
    end
    return r;
  endfunction

  task automatic drive(input logic [63:0] d, input logic [63:0] s,
                       input logic [1:0] sz, input string tag);
    @(negedge clk);
    dst_i = d; src_i = s; size_i = sz; in_valid = 1'b1;
    q_mask.push_back(model(d, s, sz));
    q_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      dst_i = {$urandom, $urandom};
      src_i = {$urandom, $urandom};
      size_i = 2'($urandom);
    end
  endtask

  always @(posedge clk) begin
    exp_v   <= rst ? 1'b0 : in_valid;
    exp_rst <= rst;
  end

  // Monitor
  always @(posedge clk) begin
    #1;
    compared++;
    if (out_valid !== exp_v) begin
      mismatched++;
      $display("FAIL %s valid: actual=%b expected=%b", exp_rst ? "R1" : "R2", out_valid, exp_v);
    end
    if (exp_rst) begin
      last_mask = '0;
      compared++;
      if (mask_o !== 64'h0) begin
        mismatched++;
        $display("FAIL R1 reset mask: actual=%h expected=%h", mask_o, 64'h0);
      end
    end else if (exp_v) begin
      if (q_mask.size() == 0) begin
        mismatched++;
        $display("FAIL R2 unexpected result: actual=%h expected=none", mask_o);
      end else begin
        logic [63:0] e;
        string t;
        e = q_mask.pop_front();
        t = q_tag.pop_front();
        last_mask = e;
        compared++;
        if (mask_o !== e) begin
          mismatched++;
          $display("FAIL %s mask: actual=%h expected=%h", t, mask_o, e);
        end
      end
    end else begin
      compared++;
      if (mask_o !== last_mask) begin
        mismatched++;
        $display("FAIL R10 hold: actual=%h expected=%h", mask_o, last_mask);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL R2 watchdog: actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(2);
    // R3 byte lanes with mixed signs and edge values
    drive(64'h807F01FF_001080F5, 64'h7F80FF01_0010F1F4, 2'b00, "R3");
    drive(64'hFF00FF00_7F7F8080, 64'h00FF00FF_807F7F80, 2'b00, "R3");
    // R4 word lanes
    drive(64'h80007FFF_0001FFFF, 64'h7FFF8000_FFFF0000, 2'b01, "R4");
    drive(64'h0100FF00_8001FFFE, 64'h00FFFF01_8000FFFF, 2'b01, "R4");
    // R5 doubleword lanes
    drive(64'h80000000_7FFFFFFF, 64'h7FFFFFFF_80000000, 2'b10, "R5");
    drive(64'h00000001_FFFFFFFF, 64'h00000000_FFFFFFFE, 2'b10, "R5");
    // R6 equal lanes in every size
    drive(64'h80017FFE_12345678, 64'h80017FFE_12345678, 2'b00, "R6");
    drive(64'h80017FFE_12345678, 64'h80017FFE_12345678, 2'b01, "R6");
    drive(64'h80000000_80000000, 64'h80000000_80000000, 2'b10, "R6");
    // R7 lanes whose low bytes disagree with the lane result
    drive(64'h0100_00FF_FF00_0001, 64'h00FF_0100_FEFF_0002, 2'b01, "R7");
    drive(64'h00000100_FFFFFF00, 64'h000000FF_FFFFFEFF, 2'b10, "R7");
    // R8 reserved size code
    drive(64'h7F7F7F7F_7F7F7F7F, 64'h80808080_80808080, 2'b11, "R8");
    // R9 borrow or sign must not cross a lane edge
    drive(64'h00000000_00000000, 64'h00000000_00000001, 2'b10, "R9");
    drive(64'h00FF00FF_00FF00FF, 64'h01000100_01000100, 2'b00, "R9");
    drive(64'h00010000_80000000, 64'h0000FFFF_7FFFFFFF, 2'b01, "R9");
    idle(4);
    // R2 isolated requests between idle cycles
    drive(64'h7FFFFFFF_00000000, 64'h80000000_00000000, 2'b10, "R2");
    idle(1);
    drive(64'h1, 64'h0, 2'b00, "R2");
    idle(3);
    // Random coverage of all sizes, tagged by size
    for (int i = 0; i < 300; i++) begin
      logic [1:0] sz;
      logic [63:0] d, s;
      sz = 2'($urandom);
      d = {$urandom, $urandom};
      s = (i % 5 == 0) ? d ^ {32'h0, $urandom & 32'h0101_0101} : {$urandom, $urandom};
      case (sz)
        2'b00: drive(d, s, sz, "R3");
        2'b01: drive(d, s, sz, "R4");
        2'b10: drive(d, s, sz, "R5");
        default: drive(d, s, sz, "R8");
      endcase
      if (i % 7 == 0) idle(1);
    end
    idle(4);
    compared++;
    if (q_mask.size() != 0) begin
      mismatched++;
      $display("FAIL R2 pending results: actual=%0d expected=0", q_mask.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule